// File: doc/BRIEF.md
# Two-Channel Conversion Sequencer with Data-Ready Tracking

This block is the timing controller that sits between a shared converter and the serial read-out logic of a two-channel sensor. It schedules conversions for the angular-rate channel and the temperature channel strictly in turn. It offers the converter a start pulse and a channel selector once per slot. A slot is half of the per-channel sample period, so each channel is sampled once per full period, regardless of serial traffic.

Finished results arrive on a done strobe that carries its channel and data word. A result is accepted unless a serial read is in progress. In that case it is discarded, so the word being shifted out is never replaced under the reader. An accepted result produces a one-cycle write enable for that channel's output register. It also marks the channel as holding unread data. The active-low ready output is derived from these unread marks under one of two policies: both channels unread, or at least one unread. It is forced high in two cases: for a short, fixed pulse after every accepted result, and from any completed read until the next accepted result.

An optional external sync input can hold the sequencer idle. When sync gating is enabled and the (synchronised) sync pin is low, no conversion starts. Once the pin is seen high, scheduling restarts at the beginning of a rate slot.

Top module: `conv_ready_ctrl`

## Requirements
- R1: While running, `conv_start` is high for exactly one cycle out of every SLOT_CYC = SAMPLE_CYC/2 cycles. `cur_chan` (0 = rate, 1 = temperature) toggles after each slot. Sequencing begins with rate one cycle after the first clock edge that follows reset.
- R2: With `cfg_sync_en` = 1 and `sync_pin` low, no `conv_start` is issued and `cur_chan` holds 0.
- R3: With gating enabled, a rising `sync_pin` passes a two-flop synchroniser. The first `conv_start`, for rate, is visible after the third rising clock edge following the change.
- R4: `conv_done` with `rd_active` low raises the write enable of `conv_chan` (`rate_we` for 0, `temp_we` for 1) for one cycle after the next edge, with `reg_wdata` equal to `conv_data`.
- R5: `conv_done` while `rd_active` is high produces no write enable. It leaves `reg_wdata`, the unread marks and `rdy_n` untouched.
- R6: With `cfg_all_chan` = 1, `rdy_n` is low only if both channels hold unread data.
- R7: With `cfg_all_chan` = 0, `rdy_n` is low if either channel holds unread data.
- R8: `rd_done` clears the unread mark of `rd_chan`. It drives `rdy_n` high from the next edge until the next accepted result.
- R9: After each accepted result, `rdy_n` is high for exactly PULSE_CYC cycles before the policy applies again. Without reads this yields one high pulse per slot.
- R10: During and right after reset, `rdy_n` is 1, both write enables are 0, `conv_start` is 0 and `cur_chan` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_pin | input | 1 | Asynchronous external sync input |
| cfg_all_chan | input | 1 | Ready policy: 1 = both channels unread, 0 = any channel unread |
| cfg_sync_en | input | 1 | Enable gating of conversions by sync_pin |
| conv_done | input | 1 | Converter result strobe |
| conv_chan | input | 1 | Channel of the finished result (0 rate, 1 temperature) |
| conv_data | input | DATA_W | Result word |
| rd_active | input | 1 | A serial read cycle is in progress |
| rd_done | input | 1 | A serial read has completed |
| rd_chan | input | 1 | Channel that was read |
| rdy_n | output | 1 | Active-low data-ready |
| rate_we | output | 1 | Write enable of the rate output register |
| temp_we | output | 1 | Write enable of the temperature output register |
| reg_wdata | output | DATA_W | Data for the output registers |
| cur_chan | output | 1 | Channel of the current conversion slot |
| conv_start | output | 1 | Start pulse for the converter |

## Verification
Every output is driven from registers, with one exception: `rdy_n` also reads the live policy bit. A write enable and its data therefore appear one edge after the done strobe. The unread marks, the read lock-out and the pulse timer change `rdy_n` at that same edge. A resume from sync takes three edges. The bench runs a behavioural model that advances on each rising edge and compares every output 2 ns after that edge, when registers have settled and inputs, changed only on falling edges, are stable. Directed checks sample at the same point. Each falls after the exact number of edges named above.

// File: rtl/crc_pkg.sv
package crc_pkg;
    typedef enum logic {
        CH_RATE = 1'b0,
        CH_TEMP = 1'b1
    } chan_e;

    localparam int NUM_CH = 2;

    // Ready condition under the selected policy.
    function automatic logic ready_cond(input logic all_chan, input logic [NUM_CH-1:0] unread);
        return all_chan ? (&unread) : (|unread);
    endfunction
endpackage

// File: rtl/slot_sched.sv
module slot_sched
    import crc_pkg::*;
#(
    parameter int SLOT_CYC = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_pin,
    input  logic  sync_en,
    output logic  conv_start,
    output chan_e cur_chan
);
    localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

    logic          sync_m, sync_s;
    logic          running;
    logic [CW-1:0] cnt;
    chan_e         chan;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_m  <= 1'b0;
            sync_s  <= 1'b0;
            running <= 1'b0;
            cnt     <= '0;
            chan    <= CH_RATE;
        end else begin
            sync_m <= sync_pin;
            sync_s <= sync_m;
            if (sync_en && !sync_s) begin
                running <= 1'b0;
                cnt     <= '0;
                chan    <= CH_RATE;
            end else if (!running) begin
                running <= 1'b1;
                cnt     <= '0;
                chan    <= CH_RATE;
            end else if (cnt == LAST) begin
                cnt  <= '0;
                chan <= (chan == CH_RATE) ? CH_TEMP : CH_RATE;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign conv_start = running && (cnt == '0);
    assign cur_chan   = chan;
endmodule

// File: rtl/result_gate.sv
module result_gate
    import crc_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  chan_e             conv_chan,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd_active,
    output logic              accept,
    output logic [NUM_CH-1:0] we,
    output logic [DATA_W-1:0] wdata
);
    assign accept = conv_done && !rd_active;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        always_ff @(posedge clk) begin
            if (rst) we[c] <= 1'b0;
            else     we[c] <= accept && (conv_chan == chan_e'(c));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         wdata <= '0;
        else if (accept) wdata <= conv_data;
    end
endmodule

// File: rtl/ready_track.sv
module ready_track
    import crc_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  chan_e acc_chan,
    input  logic  rd_done,
    input  chan_e rd_chan,
    input  logic  all_chan,
    output logic  rdy_n
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYC);

    logic [NUM_CH-1:0] unread;
    logic              consumed;
    logic [PW-1:0]     hold;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                                       unread[c] <= 1'b0;
            else if (accept && acc_chan == chan_e'(c))     unread[c] <= 1'b1;
            else if (rd_done && rd_chan == chan_e'(c))     unread[c] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            consumed <= 1'b0;
            hold     <= '0;
        end else begin
            if (accept)       consumed <= 1'b0;
            else if (rd_done) consumed <= 1'b1;
            if (accept)          hold <= PLOAD;
            else if (hold != '0) hold <= hold - 1'b1;
        end
    end

    assign rdy_n = !(ready_cond(all_chan, unread) && !consumed && (hold == '0));
endmodule

// File: rtl/conv_ready_ctrl.sv
module conv_ready_ctrl
    import crc_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int SAMPLE_CYC = 17544,
    parameter int PULSE_CYC  = 2600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_pin,
    input  logic              cfg_all_chan,
    input  logic              cfg_sync_en,
    input  logic              conv_done,
    input  logic              conv_chan,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd_active,
    input  logic              rd_done,
    input  logic              rd_chan,
    output logic              rdy_n,
    output logic              rate_we,
    output logic              temp_we,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              cur_chan,
    output logic              conv_start
);
    localparam int SLOT_CYC = SAMPLE_CYC / 2;

    chan_e             slot_chan;
    logic              accept;
    logic [NUM_CH-1:0] we;

    slot_sched #(.SLOT_CYC(SLOT_CYC)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .sync_pin   (sync_pin),
        .sync_en    (cfg_sync_en),
        .conv_start (conv_start),
        .cur_chan   (slot_chan)
    );

    result_gate #(.DATA_W(DATA_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .conv_chan (chan_e'(conv_chan)),
        .conv_data (conv_data),
        .rd_active (rd_active),
        .accept    (accept),
        .we        (we),
        .wdata     (reg_wdata)
    );

    ready_track #(.PULSE_CYC(PULSE_CYC)) u_ready (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .acc_chan (chan_e'(conv_chan)),
        .rd_done  (rd_done),
        .rd_chan  (chan_e'(rd_chan)),
        .all_chan (cfg_all_chan),
        .rdy_n    (rdy_n)
    );

    assign rate_we  = we[CH_RATE];
    assign temp_we  = we[CH_TEMP];
    assign cur_chan = logic'(slot_chan);
endmodule

// File: rtl/crc_chk.sv
module crc_chk (
    input logic clk,
    input logic rst,
    input logic sync_pin,
    input logic cfg_sync_en,
    input logic conv_done,
    input logic conv_chan,
    input logic rd_active,
    input logic rd_done,
    input logic rdy_n,
    input logic rate_we,
    input logic temp_we,
    input logic conv_start
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    // R4
    rate_we_src_chk: assert property (@(posedge clk) disable iff (rst)
        rate_we |-> $past(conv_done && !rd_active && !conv_chan));

    // R4
    temp_we_src_chk: assert property (@(posedge clk) disable iff (rst)
        temp_we |-> $past(conv_done && !rd_active && conv_chan));

    // R5
    collision_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && rd_active) |=> (!rate_we && !temp_we));

    // R8
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !(conv_done && !rd_active)) |=> rdy_n);

    // R9
    update_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !rd_active) |=> rdy_n);

    // R1
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R2
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(cfg_sync_en) && !$past(sync_pin, 2)) |-> !conv_start);
endmodule

bind conv_ready_ctrl crc_chk u_chk (.*);

// File: tb/sim_conv_ready_ctrl.sv
`timescale 1ns/1ps
module sim_conv_ready_ctrl;
    localparam int DW = 24;
    localparam int SAMP = 40;
    localparam int SLOT = SAMP / 2;
    localparam int PULSE = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_pin = 1'b0, cfg_all_chan = 1'b0, cfg_sync_en = 1'b0;
    logic conv_done = 1'b0, conv_chan = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic rd_active = 1'b0, rd_done = 1'b0, rd_chan = 1'b0;
    logic rdy_n, rate_we, temp_we, cur_chan, conv_start;
    logic [DW-1:0] reg_wdata;

    int checks = 0, fails = 0;
    string phase = "R10";

    always #4 clk = ~clk;

    conv_ready_ctrl #(.DATA_W(DW), .SAMPLE_CYC(SAMP), .PULSE_CYC(PULSE)) u0 (.*);

    // behavioural reference
    int m_pipe[$];
    bit m_run; int m_cnt; bit m_ch;
    bit m_wr, m_wt; logic [DW-1:0] m_wd;
    bit m_f0, m_f1, m_lock; int m_hold;

    initial begin
        m_pipe = '{0, 0};
    end

    always @(posedge clk) begin
        int s2;
        bit acc;
        s2 = m_pipe[0];
        void'(m_pipe.pop_front());
        m_pipe.push_back(int'(sync_pin));
        if (rst) begin
            m_pipe = '{0, 0};
            m_run = 0; m_cnt = 0; m_ch = 0;
            m_wr = 0; m_wt = 0; m_wd = '0;
            m_f0 = 0; m_f1 = 0; m_lock = 0; m_hold = 0;
        end else begin
            if (cfg_sync_en && s2 == 0) begin m_run = 0; m_cnt = 0; m_ch = 0; end
            else if (!m_run) begin m_run = 1; m_cnt = 0; m_ch = 0; end
            else if (m_cnt == SLOT - 1) begin m_cnt = 0; m_ch = !m_ch; end
            else m_cnt++;
            acc = conv_done && !rd_active;
            m_wr = acc && !conv_chan;
            m_wt = acc && conv_chan;
            if (acc) m_wd = conv_data;
            if (acc && !conv_chan) m_f0 = 1; else if (rd_done && !rd_chan) m_f0 = 0;
            if (acc && conv_chan) m_f1 = 1; else if (rd_done && rd_chan) m_f1 = 0;
            if (acc) m_lock = 0; else if (rd_done) m_lock = 1;
            if (acc) m_hold = PULSE; else if (m_hold > 0) m_hold--;
        end
    end

    function automatic bit exp_rdy_n();
        bit c;
        c = cfg_all_chan ? (m_f0 && m_f1) : (m_f0 || m_f1);
        return !(c && !m_lock && m_hold == 0);
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison
    always @(posedge clk) begin
        #2;
        chk(phase, "conv_start", conv_start, m_run && m_cnt == 0);
        chk(phase, "cur_chan", cur_chan, m_ch);
        chk(phase, "rate_we", rate_we, m_wr);
        chk(phase, "temp_we", temp_we, m_wt);
        chk(phase, "reg_wdata", reg_wdata, m_wd);
        chk(phase, "rdy_n", rdy_n, exp_rdy_n());
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic result(input bit ch, input logic [DW-1:0] d);
        @(negedge clk);
        conv_done = 1; conv_chan = ch; conv_data = d;
        @(negedge clk);
        conv_done = 0;
    endtask

    task automatic read_chan(input bit ch);
        @(negedge clk);
        rd_active = 1; rd_chan = ch;
        cyc(2);
        rd_active = 0; rd_done = 1;
        @(negedge clk);
        rd_done = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int starts;
        cyc(3);
        // R10 reset state
        chk("R10", "rdy_n", rdy_n, 1);
        chk("R10", "we", {rate_we, temp_we}, 0);
        chk("R10", "conv_start", conv_start, 0);
        rst = 0;
        @(posedge clk); #2;
        chk("R10", "cur_chan", cur_chan, 0);
        @(negedge clk);

        phase = "R1";
        starts = 0;
        repeat (3 * SLOT) begin
            @(posedge clk); #2;
            if (conv_start) starts++;
        end
        chk("R1", "start count", starts, 3);

        phase = "R7";
        cfg_all_chan = 0;
        result(0, 24'hA1B2C3);
        @(posedge clk); #1;
        chk("R9", "rdy_n during pulse", rdy_n, 1);
        cyc(PULSE + 1);
        chk("R7", "rdy_n one unread", rdy_n, 0);

        phase = "R8";
        read_chan(0);
        chk("R8", "rdy_n after read", rdy_n, 1);
        cyc(4);

        phase = "R6";
        cfg_all_chan = 1;
        result(1, 24'h00FF11);
        cyc(PULSE + 2);
        chk("R6", "rdy_n temp only", rdy_n, 1);
        result(0, 24'h123456);
        cyc(PULSE + 2);
        chk("R6", "rdy_n both unread", rdy_n, 0);

        phase = "R5";
        @(negedge clk);
        rd_active = 1;
        result(0, 24'hDEAD00);
        chk("R5", "rate_we on collision", rate_we, 0);
        chk("R5", "reg_wdata kept", reg_wdata, 24'h123456);
        chk("R5", "rdy_n kept", rdy_n, 0);
        rd_active = 0;
        cyc(3);

        phase = "R9";
        for (int i = 0; i < 4; i++) begin
            result(i[0], DW'(i * 3 + 7));
            cyc(SLOT / 2);
        end

        phase = "R2";
        cfg_sync_en = 1; sync_pin = 0;
        cyc(3);
        starts = 0;
        repeat (2 * SLOT) begin
            @(posedge clk); #2;
            if (conv_start) starts++;
        end
        chk("R2", "starts while held", starts, 0);
        chk("R2", "cur_chan held", cur_chan, 0);

        phase = "R3";
        @(negedge clk);
        sync_pin = 1;
        repeat (2) @(posedge clk);
        #2;
        chk("R3", "no start yet", conv_start, 0);
        @(posedge clk); #2;
        chk("R3", "resume start", conv_start, 1);
        chk("R3", "resume chan", cur_chan, 0);
        cyc(2 * SLOT);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule